// File: doc/BRIEF.md
# Firmware Memory Window Decoder

This block sits between a host memory-cycle front end and a serial flash bridge. For every strobed host memory cycle it decides whether the 32-bit address falls into one of the fixed firmware windows that map onto the serial flash, whether that window is switched on in the configuration, and whether the cycle type may pass. A cycle that qualifies is reported as a hit together with a 19-bit flash offset, so that all windows alias into a single 512 KiB flash space. The bridge that performs the serial transfer is outside this block.

A six-bit configuration field controls the decode. Bit 0 suspends translation completely. Bits 1, 2 and 3 each switch on a group of windows. Bit 4 allows host writes to be forwarded. Bit 5 chooses which of two package pins drives the flash chip-select. The decision is registered: it appears one clock after the strobed cycle and is held for exactly that one clock.

The control is a four-state machine. S_IDLE means no cycle was strobed in the previous clock. S_READ_FWD means a forwarded read. S_WRITE_FWD means a forwarded write. S_REJECT means a strobed cycle that was not forwarded. From any state, the machine takes one of four transitions on each clock. A strobed read that qualifies goes to S_READ_FWD. A strobed write that qualifies goes to S_WRITE_FWD. A strobed cycle that does not qualify goes to S_REJECT. A clock with no strobe goes to S_IDLE.

Top module: `fwd_win_decoder`

## Requirements
- R1: While reset is held, and on the first clock after it is released, fwd_hit, fwd_wr_ok, cs_route and fwd_ofs are all zero.
- R2: Config bit 1 enables both the top window 0xFFFE0000–0xFFFFFFFF and the low legacy window 0x000E0000–0x000FFFFF. With bit 1 clear, neither window hits.
- R3: Config bit 2 enables the window 0xFFEE0000–0xFFEFFFFF.
- R4: Config bit 3 enables the window 0xFFF80000–0xFFFEFFFF.
- R5: An address outside every window never hits, whatever the configuration. This includes addresses one below and one above each window edge, such as 0x000DFFFF, 0x00100000, 0xFFEDFFFF, 0xFFF00000 and 0xFFF7FFFF.
- R6: When config bit 0 (suspend) is set, no cycle hits. When bits 3:1 are all zero, no cycle hits.
- R7: A strobed write hits only when config bit 4 is set. Bit 4 has no effect on reads. fwd_wr_ok is 1 exactly when the forwarded cycle is a write.
- R8: On a hit, fwd_ofs equals the low 19 bits of the cycle address. Without a hit, fwd_ofs is zero.
- R9: The result of a cycle strobed at clock edge k appears after edge k and lasts one clock. A clock without a strobe leaves fwd_hit and fwd_wr_ok low on the following clock.
- R10: On a hit, cs_route equals config bit 5 as sampled with the cycle. Without a hit, cs_route is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_strb | input | 1 | A host memory cycle is presented this clock |
| cyc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_addr | input | 32 | Host memory address of the cycle |
| cfg_bits | input | 6 | Configuration: [0] suspend, [1] top+legacy windows, [2] window at 0xFFEE0000, [3] window at 0xFFF80000, [4] write forwarding, [5] chip-select pin choice |
| fwd_hit | output | 1 | The previous clock's cycle is forwarded to the flash |
| fwd_wr_ok | output | 1 | The forwarded cycle is a write |
| fwd_ofs | output | 19 | Flash offset of the forwarded cycle |
| cs_route | output | 1 | Which chip-select pin carries the forwarded cycle |

## Verification
A wrong state register shows at the ports on the clock right after the strobed cycle. A stale hit state would keep fwd_hit high through a clock with no strobe. A state mixed up between write and read would flip fwd_wr_ok. A reject state entered by mistake would drop a hit that the bench expects. A window edge that is off by one shows only at the exact boundary addresses, so those addresses are applied directly with every relevant enable pattern. A mistake in the capture of the offset or the pin choice shows the first time a hit follows a cycle with different low address bits or a different bit 5.

// File: rtl/fwd_win_pkg.sv
package fwd_win_pkg;

    localparam int ADDR_W  = 32;
    localparam int CFG_W   = 6;
    localparam int OFS_W   = 19;
    localparam int NUM_WIN = 4;

    // positions inside the configuration field
    localparam int CFG_SUSPEND = 0;
    localparam int CFG_WR_EN   = 4;
    localparam int CFG_PIN     = 5;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [2:0]        en_bit;
    } win_t;

    // inclusive address ranges and the config bit gating each
    localparam win_t WIN_TABLE [NUM_WIN] = '{
        '{lo: 32'hFFFE_0000, hi: 32'hFFFF_FFFF, en_bit: 3'd1},
        '{lo: 32'h000E_0000, hi: 32'h000F_FFFF, en_bit: 3'd1},
        '{lo: 32'hFFEE_0000, hi: 32'hFFEF_FFFF, en_bit: 3'd2},
        '{lo: 32'hFFF8_0000, hi: 32'hFFFE_FFFF, en_bit: 3'd3}
    };

    typedef enum logic [1:0] {
        V_NONE   = 2'd0,
        V_READ   = 2'd1,
        V_WRITE  = 2'd2,
        V_REJECT = 2'd3
    } verdict_t;

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_READ_FWD  = 2'd1,
        S_WRITE_FWD = 2'd2,
        S_REJECT    = 2'd3
    } state_t;

endpackage

// File: rtl/fwd_win_match.sv
module fwd_win_match
    import fwd_win_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NUM_WIN
) (
    input  logic [AW-1:0] addr,
    output logic [NW-1:0] in_win
);
    for (genvar i = 0; i < NW; i++) begin : g_win
        assign in_win[i] = (addr >= WIN_TABLE[i].lo[AW-1:0]) &&
                           (addr <= WIN_TABLE[i].hi[AW-1:0]);
    end
endmodule

// File: rtl/fwd_win_gate.sv
module fwd_win_gate
    import fwd_win_pkg::*;
#(
    parameter int NW = NUM_WIN,
    parameter int CW = CFG_W
) (
    input  logic          strb,
    input  logic          wr,
    input  logic [NW-1:0] in_win,
    input  logic [CW-1:0] cfg,
    output verdict_t      verdict
);
    logic [NW-1:0] win_on;
    logic          any_win;
    logic          allowed;

    for (genvar i = 0; i < NW; i++) begin : g_en
        assign win_on[i] = in_win[i] & cfg[WIN_TABLE[i].en_bit];
    end

    assign any_win = |win_on;
    assign allowed = any_win && !cfg[CFG_SUSPEND] && (!wr || cfg[CFG_WR_EN]);

    always_comb begin
        if (!strb)
            verdict = V_NONE;
        else if (!allowed)
            verdict = V_REJECT;
        else if (wr)
            verdict = V_WRITE;
        else
            verdict = V_READ;
    end
endmodule

// File: rtl/fwd_win_decoder.sv
module fwd_win_decoder
    import fwd_win_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CFG_W,
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_strb,
    input  logic          cyc_wr,
    input  logic [AW-1:0] cyc_addr,
    input  logic [CW-1:0] cfg_bits,
    output logic          fwd_hit,
    output logic          fwd_wr_ok,
    output logic [OW-1:0] fwd_ofs,
    output logic          cs_route
);
    logic [NUM_WIN-1:0] in_win;
    verdict_t           verdict;
    state_t             state_q, state_d;
    logic [OW-1:0]      ofs_q;
    logic               pin_q;

    fwd_win_match #(.AW(AW), .NW(NUM_WIN)) u_match (
        .addr   (cyc_addr),
        .in_win (in_win)
    );

    fwd_win_gate #(.NW(NUM_WIN), .CW(CW)) u_gate (
        .strb    (cyc_strb),
        .wr      (cyc_wr),
        .in_win  (in_win),
        .cfg     (cfg_bits),
        .verdict (verdict)
    );

    always_comb begin
        unique case (verdict)
            V_NONE:   state_d = S_IDLE;
            V_READ:   state_d = S_READ_FWD;
            V_WRITE:  state_d = S_WRITE_FWD;
            V_REJECT: state_d = S_REJECT;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ofs_q   <= '0;
            pin_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cyc_strb) begin
                ofs_q <= cyc_addr[OW-1:0];
                pin_q <= cfg_bits[CFG_PIN];
            end
        end
    end

    always_comb begin
        fwd_hit   = 1'b0;
        fwd_wr_ok = 1'b0;
        fwd_ofs   = '0;
        cs_route  = 1'b0;
        unique case (state_q)
            S_IDLE, S_REJECT: ;
            S_READ_FWD: begin
                fwd_hit  = 1'b1;
                fwd_ofs  = ofs_q;
                cs_route = pin_q;
            end
            S_WRITE_FWD: begin
                fwd_hit   = 1'b1;
                fwd_wr_ok = 1'b1;
                fwd_ofs   = ofs_q;
                cs_route  = pin_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fwd_win_decoder_chk.sv
module fwd_win_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_strb,
    input logic        cyc_wr,
    input logic [31:0] cyc_addr,
    input logic [5:0]  cfg_bits,
    input logic        fwd_hit,
    input logic        fwd_wr_ok,
    input logic [18:0] fwd_ofs,
    input logic        cs_route
);
    // R6
    suspend_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strb && cfg_bits[0] |=> !fwd_hit);

    // R6
    no_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strb && (cfg_bits[3:1] == 3'b000) |=> !fwd_hit);

    // R7
    write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strb && cyc_wr && !cfg_bits[4] |=> !fwd_hit);

    // R7
    wr_ok_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strb |=> (fwd_wr_ok == (fwd_hit && $past(cyc_wr))));

    // R8
    offset_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strb |=> (!fwd_hit || fwd_ofs == $past(cyc_addr[18:0])));

    // R8
    offset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_hit |-> fwd_ofs == 19'd0);

    // R9
    idle_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_strb |=> !fwd_hit && !fwd_wr_ok);

    // R10
    route_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strb |=> (cs_route == (fwd_hit && $past(cfg_bits[5]))));
endmodule

bind fwd_win_decoder fwd_win_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_strb  (cyc_strb),
    .cyc_wr    (cyc_wr),
    .cyc_addr  (cyc_addr),
    .cfg_bits  (cfg_bits),
    .fwd_hit   (fwd_hit),
    .fwd_wr_ok (fwd_wr_ok),
    .fwd_ofs   (fwd_ofs),
    .cs_route  (cs_route)
);

// File: tb/fwd_win_decoder_tb.sv
module fwd_win_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_strb = 1'b0;
    logic        cyc_wr = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic [5:0]  cfg_bits = '0;
    logic        fwd_hit, fwd_wr_ok, cs_route;
    logic [18:0] fwd_ofs;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fwd_win_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_strb(cyc_strb), .cyc_wr(cyc_wr),
        .cyc_addr(cyc_addr), .cfg_bits(cfg_bits), .fwd_hit(fwd_hit),
        .fwd_wr_ok(fwd_wr_ok), .fwd_ofs(fwd_ofs), .cs_route(cs_route)
    );

    // expected {hit, wr_ok, route, ofs}
    function automatic logic [21:0] model(input logic s, input logic w,
                                          input logic [31:0] a, input logic [5:0] c);
        logic in_a, in_b, in_c, hit;
        in_a = (a >= 32'hFFFE0000) || (a >= 32'h000E0000 && a <= 32'h000FFFFF);
        in_b = (a >= 32'hFFEE0000) && (a <= 32'hFFEFFFFF);
        in_c = (a >= 32'hFFF80000) && (a <= 32'hFFFEFFFF);
        hit  = s && ((in_a && c[1]) || (in_b && c[2]) || (in_c && c[3])) &&
               !c[0] && (!w || c[4]);
        return {hit, hit && w, hit && c[5], hit ? a[18:0] : 19'd0};
    endfunction

    task automatic check(input string req, input logic [21:0] exp);
        logic [21:0] act;
        act = {fwd_hit, fwd_wr_ok, cs_route, fwd_ofs};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got hit=%b wr=%b pin=%b ofs=%h, expected hit=%b wr=%b pin=%b ofs=%h",
                     req, act[21], act[20], act[19], act[18:0],
                     exp[21], exp[20], exp[19], exp[18:0]);
        end
    endtask

    // drive at a falling edge, result visible after the next rising edge
    task automatic apply(input string req, input logic s, input logic w,
                         input logic [31:0] a, input logic [5:0] c);
        @(negedge clk);
        cyc_strb = s; cyc_wr = w; cyc_addr = a; cfg_bits = c;
        @(negedge clk);
        check(req, model(s, w, a, c));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_out;
        seed_out = $urandom(32'd1977);
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 in reset", 22'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 22'd0);

        // R2: both bit-1 windows, and off with bit 1 clear
        apply("R2 top low edge",   1, 0, 32'hFFFE0000, 6'b000010);
        apply("R2 top high edge",  1, 0, 32'hFFFFFFFF, 6'b000010);
        apply("R2 legacy low",     1, 0, 32'h000E0000, 6'b000010);
        apply("R2 legacy high",    1, 0, 32'h000FFFFF, 6'b000010);
        apply("R2 disabled",       1, 0, 32'hFFFF1234, 6'b001100);
        // R3
        apply("R3 low edge",       1, 0, 32'hFFEE0000, 6'b000100);
        apply("R3 high edge",      1, 0, 32'hFFEFFFFF, 6'b000100);
        apply("R3 disabled",       1, 0, 32'hFFEE8000, 6'b001010);
        // R4
        apply("R4 low edge",       1, 0, 32'hFFF80000, 6'b001000);
        apply("R4 high edge",      1, 0, 32'hFFFEFFFF, 6'b001000);
        apply("R4 next is bit1",   1, 0, 32'hFFFF0000, 6'b001000);
        // R5: just outside each window
        apply("R5 below legacy",   1, 0, 32'h000DFFFF, 6'b001110);
        apply("R5 above legacy",   1, 0, 32'h00100000, 6'b001110);
        apply("R5 below 0xFFEE",   1, 0, 32'hFFEDFFFF, 6'b001110);
        apply("R5 above 0xFFEF",   1, 0, 32'hFFF00000, 6'b001110);
        apply("R5 below 0xFFF8",   1, 0, 32'hFFF7FFFF, 6'b001110);
        // R6
        apply("R6 suspend",        1, 0, 32'hFFFE4000, 6'b011111);
        apply("R6 no segments",    1, 0, 32'hFFFE4000, 6'b110000);
        // R7
        apply("R7 write blocked",  1, 1, 32'hFFFA0000, 6'b001000);
        apply("R7 write passed",   1, 1, 32'hFFFA0000, 6'b011000);
        apply("R7 read no wr_en",  1, 0, 32'hFFFA0000, 6'b001000);
        // R8 / R10: offset and pin capture
        apply("R8 offset alias",   1, 0, 32'h000E7ABC, 6'b100010);
        apply("R10 pin select",    1, 1, 32'hFFEF0001, 6'b110100);
        // R9: one-clock result, idle without strobe
        apply("R9 hit",            1, 0, 32'hFFFFFFF0, 6'b100010);
        apply("R9 gap",            0, 0, 32'hFFFFFFF0, 6'b100010);
        apply("R9 gap write",      0, 1, 32'hFFFFFFF0, 6'b110010);

        // random mix, biased toward the windows
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            logic [5:0]  c;
            int pick;
            pick = $urandom_range(0, 5);
            case (pick)
                0: a = 32'hFFFE0000 | ($urandom & 32'h0001FFFF);
                1: a = 32'h000E0000 | ($urandom & 32'h0001FFFF);
                2: a = 32'hFFEE0000 | ($urandom & 32'h0001FFFF);
                3: a = 32'hFFF80000 + ($urandom % 32'h00070000);
                4: a = 32'hFFE00000 | ($urandom & 32'h001FFFFF);
                default: a = $urandom;
            endcase
            c = 6'($urandom);
            apply("R2-R10 random", $urandom_range(0, 3) != 0, 1'($urandom), a, c);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule